// File: doc/BRIEF.md
# Four-Mode Function Register

This block is a small clocked register with a parallel output word and two serial fill inputs. On each rising clock edge, a 2-bit mode code picks one of four updates. The register can add three to itself, invert all of its bits, move its contents one place toward the most significant bit, or move them one place toward the least significant bit. A shift toward the MSB takes its new bit 0 from the low-side serial input. A shift toward the LSB takes its new top bit from the high-side serial input.

There is no idle or hold mode, so the register changes on every edge unless reset is high. A host can place any value in the register by issuing one shift per bit. The register width and the added constant are parameters, and the defaults are 4 bits and three. The mode pins and serial pins are plain control inputs sampled at the clock edge. There is no handshake, because every edge commits an update.

Top module: `quad_mode_reg`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes 0000 on that edge.
- R2: With mode 2'b00, `q` takes the value `q + 3` on the next edge.
- R3: The addition in mode 2'b00 is modulo 16 and any carry out of bit 3 is lost. For example, 13 becomes 0 and 15 becomes 2.
- R4: With mode 2'b01, `q` becomes `{q[2:0], sin_lo}`, which moves the bits toward the MSB and fills bit 0 from `sin_lo`.
- R5: With mode 2'b11, `q` becomes `{sin_hi, q[3:1]}`, which moves the bits toward the LSB and fills bit 3 from `sin_hi`.
- R6: With mode 2'b10, every bit of `q` is inverted on the next edge.
- R7: `sin_hi` has no effect in modes 00, 01 and 10, and `sin_lo` has no effect in modes 00, 10 and 11.
- R8: Reset takes priority over every mode code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | Update select: 00 add three, 01 shift toward MSB, 10 invert, 11 shift toward LSB |
| sin_lo | input | 1 | Serial bit that enters bit 0 on a shift toward the MSB |
| sin_hi | input | 1 | Serial bit that enters bit 3 on a shift toward the LSB |
| q | output | 4 | Parallel register contents |

## Verification
The assertions assume that `mode`, `sin_lo` and `sin_hi` hold known values at every sampled edge after the first reset. They also assume that reset is applied before any property is meaningful, so the checker keeps track of whether a reset has been seen. The stimulus drives every input on the falling edge and never leaves any of them undriven. It opens with two reset cycles, then loads values through shifts and sweeps all four codes. It also toggles the unused serial pin in each mode, so that R7 stays inside those assumptions.

// File: rtl/quad_mode_pkg.sv
package quad_mode_pkg;
  typedef enum logic [1:0] {
    QM_ADDK = 2'b00,
    QM_UP   = 2'b01,
    QM_INV  = 2'b10,
    QM_DOWN = 2'b11
  } qm_mode_e;
endpackage

// File: rtl/qm_addk.sv
module qm_addk #(
  parameter int W = 4,
  parameter int K = 3
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] KW = W'(K);
  // modulo 2^W: carry out is dropped by the width
  assign y = a + KW;
endmodule

// File: rtl/qm_shift.sv
module qm_shift #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic         fill_lo,
  input  logic         fill_hi,
  output logic [W-1:0] up,
  output logic [W-1:0] down
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
        assign up[i] = fill_lo;
      end else begin : g_lo_n
        assign up[i] = a[i-1];
      end
      if (i == W-1) begin : g_hi
        assign down[i] = fill_hi;
      end else begin : g_hi_n
        assign down[i] = a[i+1];
      end
    end
  endgenerate
endmodule

// File: rtl/qm_select.sv
module qm_select
  import quad_mode_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] up,
  input  logic [W-1:0] down,
  output logic [W-1:0] nxt
);
  qm_mode_e m;
  assign m = qm_mode_e'(mode);

  always_comb begin
    unique case (m)
      QM_ADDK: nxt = sum;
      QM_UP:   nxt = up;
      QM_INV:  nxt = ~cur;
      QM_DOWN: nxt = down;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/quad_mode_reg.sv
module quad_mode_reg #(
  parameter int W = 4,
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         sin_lo,
  input  logic         sin_hi,
  output logic [W-1:0] q
);
  logic [W-1:0] state_q;
  logic [W-1:0] sum_w, up_w, down_w, nxt_w;

  qm_addk #(.W(W), .K(K)) u_add (
    .a (state_q),
    .y (sum_w)
  );

  qm_shift #(.W(W)) u_shift (
    .a       (state_q),
    .fill_lo (sin_lo),
    .fill_hi (sin_hi),
    .up      (up_w),
    .down    (down_w)
  );

  qm_select #(.W(W)) u_sel (
    .mode (mode),
    .cur  (state_q),
    .sum  (sum_w),
    .up   (up_w),
    .down (down_w),
    .nxt  (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;   // R1, R8
    else     state_q <= nxt_w;
  end

  assign q = state_q;
endmodule

// File: rtl/quad_mode_reg_chk.sv
module quad_mode_reg_chk #(
  parameter int W = 4,
  parameter int K = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         sin_lo,
  input logic         sin_hi,
  input logic [W-1:0] q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (q == '0));

  a_r2_add_k: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 2'b00) |=> (q == W'($past(q) + K)));

  a_r4_shift_up: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 2'b01) |=> (q == {$past(q[W-2:0]), $past(sin_lo)}));

  a_r5_shift_down: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 2'b11) |=> (q == {$past(sin_hi), $past(q[W-1:1])}));

  a_r6_invert: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 2'b10) |=> (q == ~$past(q)));
endmodule

bind quad_mode_reg quad_mode_reg_chk #(.W(W), .K(K)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .sin_lo(sin_lo), .sin_hi(sin_hi), .q(q)
);

// File: tb/tb_quad_mode_reg.sv
`timescale 1ns/1ps
module tb_quad_mode_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       sin_lo = 1'b0;
  logic       sin_hi = 1'b0;
  logic [3:0] q;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  quad_mode_reg dut (
    .clk(clk), .rst(rst), .mode(mode), .sin_lo(sin_lo), .sin_hi(sin_hi), .q(q)
  );

  function automatic string auto_tag(input logic r, input logic [1:0] m, input int v);
    if (r) return "R1";
    case (m)
      2'b00:   return (v + 3 > 15) ? "R3" : "R2";
      2'b01:   return "R4";
      2'b10:   return "R6";
      default: return "R5";
    endcase
  endfunction

  // drive on negedge, reference update, compare on next negedge
  task automatic step(input logic r, input logic [1:0] m, input logic lo,
                      input logic hi, input string tag);
    string t;
    t = (tag == "") ? auto_tag(r, m, model) : tag;
    rst = r; mode = m; sin_lo = lo; sin_hi = hi;
    if (r) model = 0;
    else case (m)
      2'b00: model = (model + 3) % 16;
      2'b01: model = ((model * 2) % 16) + (lo ? 1 : 0);
      2'b10: model = 15 - model;
      default: model = (model / 2) + (hi ? 8 : 0);
    endcase
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(q) != model) begin
      errors++;
      $display("FAIL %s: q=%0d expected=%0d", t, q, model);
    end
  endtask

  task automatic load(input int v);
    for (int b = 3; b >= 0; b--) step(1'b0, 2'b01, v[b], ~v[b], "R4");
  endtask

  initial begin
    int seed;
    seed = 5;
    @(negedge clk);
    step(1'b1, 2'b00, 1'b0, 1'b0, "R1");
    step(1'b1, 2'b10, 1'b1, 1'b1, "R1");
    // load 1011 with the opposite serial pin toggling
    load(11);
    step(1'b0, 2'b10, 1'b1, 1'b0, "R6");          // 0100
    step(1'b0, 2'b11, 1'b0, 1'b1, "R5");          // 1010
    step(1'b0, 2'b11, 1'b1, 1'b0, "R7");          // sin_lo ignored: 0101
    step(1'b0, 2'b01, 1'b0, 1'b1, "R7");          // sin_hi ignored: 1010
    step(1'b0, 2'b00, 1'b1, 1'b1, "R7");          // serials ignored in add: 1101
    step(1'b0, 2'b00, 1'b0, 1'b0, "R3");          // 13 -> 0
    step(1'b0, 2'b10, 1'b1, 1'b1, "R7");          // serials ignored in invert: 1111
    step(1'b0, 2'b00, 1'b0, 1'b1, "R3");          // 15 -> 2
    step(1'b0, 2'b00, 1'b0, 1'b0, "R2");          // 5
    step(1'b1, 2'b00, 1'b1, 1'b1, "R8");          // reset beats add
    load(9);
    step(1'b1, 2'b10, 1'b0, 1'b0, "R8");          // reset beats invert
    // every start value through add three
    for (int v = 0; v < 16; v++) begin
      load(v);
      step(1'b0, 2'b00, v[0], v[1], "");
    end
    // pseudo-random stream of modes and serial bits
    for (int i = 0; i < 200; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step((seed[15:11] == 5'd0), seed[9:8], seed[4], seed[6], "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule